// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Word Bridge

This block carries single data words from a source clock domain into an unrelated destination clock domain. A source client offers a word with a one-cycle valid strobe. When the bridge is idle it latches the word into a holding register and raises a request line. The request stays high until an acknowledge comes back, and during that time the held word does not change. The destination side sees the request through its own synchronizer. It then copies the held word to its output, flags it with a one-cycle valid pulse and raises the acknowledge.

The handshake returns to zero before the next word is taken. The source drops its request once it sees the synchronized acknowledge. The destination drops the acknowledge once it sees the synchronized request fall. The source reports itself idle again only after the synchronized acknowledge has fallen. Only single-bit control lines cross between the domains, each through a flop chain in the domain that receives it. The word crosses without a synchronizer, because it is sampled only while the request qualifier guarantees it is steady. One active-low reset clears both domains.

Top module: `cdc_word_bridge`

## Requirements
- R1: While rstN is low, hsReq, hsAck, rxValid and txBusy are all 0 and rxData is 0.
- R2: Once hsReq is high, it stays high until the source domain's synchronized copy of hsAck is high. It falls only on the clkA edge after that copy was seen high.
- R3: hsAck rises only on a clkB edge where the destination's synchronized copy of hsReq was already high before the edge. It rises no more than 15 clkB edges after hsReq goes high.
- R4: hsAck falls only on a clkB edge where the synchronized copy of hsReq was already low before the edge.
- R5: With two synchronizer stages, rxValid and hsAck go high on the third clkB rising edge strictly after hsReq rises, or on the fourth edge if a clkB edge coincides with the hsReq edge.
- R6: Each accepted word produces exactly one rxValid pulse, one clkB cycle long, in the cycle where hsAck rises. rxData in that cycle equals the accepted word. Words arrive in acceptance order, with none lost or repeated.
- R7: rxData holds its value in every clkB cycle where rxValid is low.
- R8: A word is accepted only on a clkA edge where txValid is high and txBusy is low. txValid while txBusy is high is ignored and produces no output word.
- R9: txBusy goes high on the clkA edge that accepts a word. It stays high until hsReq is low and the synchronized acknowledge is low again.
- R10: hsReq and hsAck move only through the cycle (0,0) → (1,0) → (1,1) → (0,1) → (0,0), one line at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Source domain clock |
| clkB | input | 1 | Destination domain clock |
| rstN | input | 1 | Active-low reset for both domains |
| txValid | input | 1 | Source offers txData this clkA cycle |
| txData | input | DATA_W | Word offered by the source |
| txBusy | output | 1 | Transfer in progress; new offers are ignored |
| rxValid | output | 1 | One-cycle clkB pulse: rxData carries a new word |
| rxData | output | DATA_W | Delivered word, held between pulses |
| hsReq | output | 1 | Request line (clkA domain) |
| hsAck | output | 1 | Acknowledge line (clkB domain) |

## Verification
The bound checker verifies these on every clock of the domain that owns each signal: the request hold and drop rule, the cause of each acknowledge edge, the shape of the rxValid pulse, output data holding between pulses, acceptance only when idle, and a counter-based 15-edge bound on acknowledge latency. Some properties span a whole transfer, and only the bench scenarios can show them. These are end-to-end word integrity and ordering, the absence of lost or extra words when offers collide with a busy bridge, the exact synchronizer latency in clkB edges, and the legality of the full four-phase state sequence. The bench runs the two clocks at unrelated periods with a phase offset.

// File: rtl/cdc_word_bridge_pkg.sv
package cdc_word_bridge_pkg;

  // Strobes from control to datapath. capture is a clkA-domain
  // strobe, present is a clkB-domain strobe.
  typedef struct packed {
    logic capture;
    logic present;
  } xferStrobeT;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_REQ  = 2'd1,
    SRC_DRAIN = 2'd2
  } srcPhaseT;

  typedef enum logic {
    DST_IDLE = 1'b0,
    DST_ACK  = 1'b1
  } dstPhaseT;

endpackage

// File: rtl/cwb_sync.sv
module cwb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cdc_word_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clkA,
  input  logic       clkB,
  input  logic       rstN,
  input  logic       txValid,
  output logic       txBusy,
  output logic       hsReq,
  output logic       hsAck,
  output logic       reqSyncB,
  output logic       ackSyncA,
  output logic       rxValid,
  output xferStrobeT strobes
);

  srcPhaseT srcPhase;
  dstPhaseT dstPhase;
  logic     rxPulse;
  logic     captureA;
  logic     presentB;

  // Acknowledge synchronized into clkA
  cwb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) ackSync_i (
    .clk (clkA),
    .rstN(rstN),
    .d   (hsAck),
    .q   (ackSyncA)
  );

  // Request synchronized into clkB
  cwb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) reqSync_i (
    .clk (clkB),
    .rstN(rstN),
    .d   (hsReq),
    .q   (reqSyncB)
  );

  // Source side: accept only when fully returned to zero
  assign captureA = txValid && (srcPhase == SRC_IDLE) && !ackSyncA;

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      srcPhase <= SRC_IDLE;
    end else begin
      unique case (srcPhase)
        SRC_IDLE:  if (captureA) srcPhase <= SRC_REQ;
        SRC_REQ:   if (ackSyncA) srcPhase <= SRC_DRAIN;
        SRC_DRAIN: if (!ackSyncA) srcPhase <= SRC_IDLE;
        default:   srcPhase <= SRC_IDLE;
      endcase
    end
  end

  assign hsReq  = (srcPhase == SRC_REQ);
  assign txBusy = (srcPhase != SRC_IDLE);

  // Destination side: respond to a synchronized request already seen
  assign presentB = reqSyncB && (dstPhase == DST_IDLE);

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      dstPhase <= DST_IDLE;
      rxPulse  <= 1'b0;
    end else begin
      rxPulse <= presentB;
      unique case (dstPhase)
        DST_IDLE: if (presentB)  dstPhase <= DST_ACK;
        DST_ACK:  if (!reqSyncB) dstPhase <= DST_IDLE;
        default:  dstPhase <= DST_IDLE;
      endcase
    end
  end

  assign hsAck   = (dstPhase == DST_ACK);
  assign rxValid = rxPulse;

  assign strobes.capture = captureA;
  assign strobes.present = presentB;

endmodule

// File: rtl/cwb_datapath.sv
module cwb_datapath
  import cdc_word_bridge_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  xferStrobeT        strobes,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] holdWord;

  // clkA: word is frozen for the life of the request
  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)                holdWord <= '0;
    else if (strobes.capture) holdWord <= txData;
  end

  // clkB: held word sampled only while the qualifier guarantees it is steady
  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)                rxData <= '0;
    else if (strobes.present) rxData <= holdWord;
  end

endmodule

// File: rtl/cdc_word_bridge.sv
module cdc_word_bridge
  import cdc_word_bridge_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txBusy,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              hsReq,
  output logic              hsAck
);

  xferStrobeT strobes;
  logic       reqSyncB;
  logic       ackSyncA;

  cwb_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clkA    (clkA),
    .clkB    (clkB),
    .rstN    (rstN),
    .txValid (txValid),
    .txBusy  (txBusy),
    .hsReq   (hsReq),
    .hsAck   (hsAck),
    .reqSyncB(reqSyncB),
    .ackSyncA(ackSyncA),
    .rxValid (rxValid),
    .strobes (strobes)
  );

  cwb_datapath #(.DATA_W(DATA_W)) data_i (
    .clkA   (clkA),
    .clkB   (clkB),
    .rstN   (rstN),
    .strobes(strobes),
    .txData (txData),
    .rxData (rxData)
  );

endmodule

// File: rtl/cdc_word_bridge_sva.sv
module cdc_word_bridge_sva #(
  parameter int DATA_W    = 16,
  parameter int ACK_LIMIT = 15
) (
  input logic              clkA,
  input logic              clkB,
  input logic              rstN,
  input logic              txValid,
  input logic              txBusy,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic              hsReq,
  input logic              hsAck,
  input logic              reqSyncB,
  input logic              ackSyncA
);

  localparam int CNT_W = $clog2(ACK_LIMIT + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ACK_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(ACK_LIMIT);

  // clkB edges spent with the request up and no acknowledge yet
  logic [CNT_W-1:0] ackWait;
  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)                 ackWait <= '0;
    else if (hsReq && !hsAck)  ackWait <= (ackWait == CNT_MAX) ? ackWait : ackWait + 1'b1;
    else                       ackWait <= '0;
  end

  // R2: request held until the synchronized acknowledge arrives
  p_req_hold_r2: assert property (@(posedge clkA) disable iff (!rstN)
    (hsReq && !ackSyncA) |=> hsReq);

  // R2: request falls only after the synchronized acknowledge was seen
  p_req_drop_r2: assert property (@(posedge clkA) disable iff (!rstN)
    $fell(hsReq) |-> $past(ackSyncA));

  // R3: acknowledge rises only in answer to a synchronized request
  p_ack_cause_r3: assert property (@(posedge clkB) disable iff (!rstN)
    $rose(hsAck) |-> $past(reqSyncB));

  // R3: bounded wait for the acknowledge
  p_ack_latency_r3: assert property (@(posedge clkB) disable iff (!rstN)
    ackWait <= CNT_LIM);

  // R4: acknowledge falls only after the synchronized request fell
  p_ack_drop_r4: assert property (@(posedge clkB) disable iff (!rstN)
    $fell(hsAck) |-> !$past(reqSyncB));

  // R6: valid pulse coincides with the acknowledge rising
  p_rx_with_ack_r6: assert property (@(posedge clkB) disable iff (!rstN)
    rxValid |-> $rose(hsAck));

  // R6: valid pulse is a single cycle
  p_rx_pulse_r6: assert property (@(posedge clkB) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7: output word held between pulses
  p_rx_hold_r7: assert property (@(posedge clkB) disable iff (!rstN)
    !rxValid |-> $stable(rxData));

  // R8: request starts only from an offer made while idle
  p_accept_idle_r8: assert property (@(posedge clkA) disable iff (!rstN)
    $rose(hsReq) |-> $past(txValid && !txBusy));

  // R9: busy covers request and the return-to-zero phase
  p_busy_cover_r9: assert property (@(posedge clkA) disable iff (!rstN)
    (hsReq || ackSyncA) |-> txBusy);

endmodule

bind cdc_word_bridge cdc_word_bridge_sva #(.DATA_W(DATA_W)) sva_i (.*);

// File: tb/cdc_word_bridge_tb_top.sv
`timescale 1ns/1ps
module cdc_word_bridge_tb_top;

  localparam int DATA_W = 16;

  logic              clkA = 1'b0;
  logic              clkB = 1'b0;
  logic              rstN = 1'b0;
  logic              txValid = 1'b0;
  logic [DATA_W-1:0] txData = '0;
  logic              txBusy;
  logic              rxValid;
  logic [DATA_W-1:0] rxData;
  logic              hsReq;
  logic              hsAck;

  int testsRun = 0;
  int testsFailed = 0;
  int sentCnt = 0;
  int recvCnt = 0;
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] lastRx = '0;
  bit finished = 1'b0;

  always #4 clkA = ~clkA;                  // 125 MHz
  initial begin
    #2.15;
    forever #6.65 clkB = ~clkB;             // unrelated destination clock
  end

  cdc_word_bridge #(.DATA_W(DATA_W)) dut_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .txValid(txValid), .txData(txData), .txBusy(txBusy),
    .rxValid(rxValid), .rxData(rxData),
    .hsReq(hsReq), .hsAck(hsAck)
  );

  function automatic bit phaseLegal(logic [1:0] from, logic [1:0] to);
    // {req,ack}: 00 -> 10 -> 11 -> 01 -> 00
    case (from)
      2'b00:   return to == 2'b10;
      2'b10:   return to == 2'b11;
      2'b11:   return to == 2'b01;
      2'b01:   return to == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  // Offer one word when idle; optionally pester with offers while busy
  task automatic sendWord(logic [DATA_W-1:0] w, int pester);
    @(negedge clkA);
    while (txBusy) @(negedge clkA);
    txValid = 1'b1;
    txData  = w;
    expQ.push_back(w);
    sentCnt++;
    @(negedge clkA);
    check(txBusy == 1'b1, "R9 busy after accept", txBusy, 1);
    txValid = 1'b0;
    for (int k = 0; k < pester; k++) begin
      if (txBusy) begin
        txValid = 1'b1;                    // R8: must be ignored
        txData  = ~w ^ DATA_W'(k);
      end else begin
        txValid = 1'b0;
      end
      @(negedge clkA);
    end
    txValid = 1'b0;
  endtask

  // Scoreboard: word integrity, order, no extras (R6, R8) and hold (R7)
  always @(negedge clkB) begin
    if (rstN && !finished) begin
      if (rxValid) begin
        recvCnt++;
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected word", rxData, 0);
        end else begin
          logic [DATA_W-1:0] e;
          e = expQ.pop_front();
          check(rxData == e, "R6 word value/order", rxData, e);
        end
        lastRx = rxData;
      end else begin
        check(rxData == lastRx, "R7 rxData hold", rxData, lastRx);
      end
    end
  end

  // Four-phase sequence monitor (R10)
  logic [1:0] prevHs = 2'b00;
  always @(hsReq or hsAck) begin
    if (rstN && !finished) begin
      check(phaseLegal(prevHs, {hsReq, hsAck}), "R10 four-phase step",
            {hsReq, hsAck}, prevHs);
    end
    prevHs = {hsReq, hsAck};
  end

  // Synchronizer latency in clkB edges (R5)
  initial begin
    forever begin
      int n;
      @(posedge hsReq);
      n = 0;
      do begin
        @(posedge clkB);
        n++;
        @(negedge clkB);
      end while (!rxValid && n < 20);
      if (!finished)
        check(n >= 3 && n <= 4, "R5 req-to-rxValid edges", n, 3);
    end
  end

  // Watchdog
  initial begin
    #1ms;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=%0d expected=%0d received", recvCnt, sentCnt);
    finishUp();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (4) @(negedge clkA);
    check(hsReq == 1'b0,   "R1 hsReq in reset",   hsReq, 0);
    check(hsAck == 1'b0,   "R1 hsAck in reset",   hsAck, 0);
    check(rxValid == 1'b0, "R1 rxValid in reset", rxValid, 0);
    check(txBusy == 1'b0,  "R1 txBusy in reset",  txBusy, 0);
    check(rxData == '0,    "R1 rxData in reset",  rxData, 0);
    // R8: offer during reset must not be taken
    txValid = 1'b1;
    txData  = 16'hDEAD;
    @(negedge clkA);
    check(txBusy == 1'b0, "R8 no accept in reset", txBusy, 0);
    txValid = 1'b0;
    rstN = 1'b1;
    repeat (3) @(negedge clkA);

    // Directed corner words
    sendWord(16'h0000, 0);
    sendWord(16'hFFFF, 0);
    sendWord(16'hA5A5, 12);               // R8: heavy pestering while busy
    sendWord(16'h5A5A, 0);                // back-to-back after pester
    sendWord(16'h0001, 30);

    // Constrained random traffic
    for (int i = 0; i < 40; i++) begin
      int gap;
      int pest;
      gap  = int'($urandom_range(0, 6));
      pest = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 10)) : 0;
      repeat (gap) @(negedge clkA);
      sendWord(DATA_W'($urandom), pest);
    end

    // Drain and final accounting (R6, R9)
    while (expQ.size() != 0 || txBusy || hsAck) @(negedge clkA);
    repeat (4) @(negedge clkA);
    check(recvCnt == sentCnt, "R6 words delivered", recvCnt, sentCnt);
    check(txBusy == 1'b0, "R9 idle after drain", txBusy, 0);
    check({hsReq, hsAck} == 2'b00, "R10 returned to zero", {hsReq, hsAck}, 0);
    finishUp();
  end

endmodule